// File: doc/BRIEF.md
# Indexed Power-Management Register Port

This block gives software a two-byte I/O window onto a small bank of 8-bit power-management registers. A write to the first byte of the window loads a register number. The second byte then reads or writes the register that number selects. All configuration of the system watchdog passes through this indirection.

The bank holds three kinds of register. Two reset-cause status bytes record why the system last came out of reset. Their bits stay set until software writes 1 to them, and a system reset does not clear them; only a power-on reset does. One watchdog configuration byte carries a disable bit and a two-bit tick-resolution code, and both drive the watchdog counter directly. Four read-only bytes give the 32-bit base address of the memory-mapped watchdog. That address is fixed by a parameter.

The watchdog counter pulses `wd_fired` when it expires. That pulse sets the sticky watchdog-cause bit, so software can see after the resulting reset that the watchdog caused it.

Top module: `pm_index_port`

## Requirements
- R1: Offset 0 of the window is the index register. A write there stores the byte, and a read at offset 0 returns it. Both `por_n` and `rst_n` return the index to 0x00.
- R2: After reset the configuration byte at index 0x69 reads 0x01: the disable bit (bit 0) is set and the resolution code (bits 2:1) is 00. In this state `wd_enable` is 0 and `wd_res` is 00.
- R3: A data write at index 0x69 sets the following, from the clock edge of the write onward:
  - `wd_enable` becomes the inverse of bit 0.
  - `wd_res` becomes bits 2:1, coded 00 = 32 us, 01 = 10 ms, 10 = 100 ms, 11 = 1 s.
  - Bits 7:3 read back as 0.
- R4: A one-cycle pulse on `wd_fired` sets bit 1 of the status byte at index 0x45. The bit reads 1 from the next cycle on.
- R5: The watchdog-cause bit keeps its value through `rst_n`. Only `por_n` clears it.
- R6: A data write at index 0x45 clears bit 1 only when the written bit 1 is 1. Writing 0 there leaves the bit unchanged. If `wd_fired` and a clearing write arrive in the same cycle, the bit stays set.
- R7: The status byte at index 0x44 reads 0x01 after a power-on reset, and `rst_n` does not change it. A data write with bit 0 set clears the byte.
- R8: Indices 0x6c, 0x6d, 0x6e and 0x6f read bytes 0 to 3 of the `BASE_ADDR` parameter, with the least significant byte at 0x6c. Writes to these indices have no effect.
- R9: A data read at an index with no register returns 0x00. A data write to such an index changes no register.
- R10: While `rst_n` is low, the index register and the configuration byte are held at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears every register |
| rst_n | input | 1 | System reset, active low, asynchronous; leaves the status bytes alone |
| addr | input | 1 | Window offset: 0 = index, 1 = data |
| wr | input | 1 | Write strobe for the byte at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the byte at `addr` (combinational) |
| wd_fired | input | 1 | Pulse from the watchdog counter on expiry |
| wd_enable | output | 1 | Watchdog enabled (inverse of the disable bit) |
| wd_res | output | 2 | Watchdog tick-resolution code |

## Verification
The assertions assume that `wr` is a single-cycle strobe and that `wd_fired` is a synchronous pulse. They also assume that no bus write arrives while `rst_n` is low, so status clears during system reset are not checked. The bench drives every input on the falling edge and keeps `wr` low whenever a reset is asserted. It raises `wd_fired` only while both resets are high, and in one cycle it raises `wd_fired` together with a clearing write to check which one wins.

// File: rtl/pm_index_port.sv
module pm_index_port #(
  parameter logic [31:0] BASE_ADDR = 32'hFEB0_0000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       wd_fired,
  output logic       wd_enable,
  output logic [1:0] wd_res
);
  localparam logic [7:0] IDX_STAT0 = 8'h44;
  localparam logic [7:0] IDX_STAT1 = 8'h45;
  localparam logic [7:0] IDX_CFG   = 8'h69;
  localparam logic [7:0] IDX_BASE0 = 8'h6c;
  localparam logic [7:0] IDX_BASE1 = IDX_BASE0 + 8'd1;
  localparam logic [7:0] IDX_BASE2 = IDX_BASE0 + 8'd2;
  localparam logic [7:0] IDX_BASE3 = IDX_BASE0 + 8'd3;
  localparam int         WD_BIT    = 1;

  logic       sys_rst_n;
  logic       idx_wr, data_wr;
  logic [7:0] idx_q;
  logic [2:0] cfg_q;
  logic       por_sts_q;
  logic       wd_sts_q;

  assign sys_rst_n = por_n & rst_n;
  assign idx_wr    = wr & ~addr;
  assign data_wr   = wr & addr;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      idx_q <= 8'h00;
      cfg_q <= 3'b001;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (data_wr && idx_q == IDX_CFG) cfg_q <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      por_sts_q <= 1'b1;
    else if (rst_n && data_wr && idx_q == IDX_STAT0 && wdata[0])
      por_sts_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      wd_sts_q <= 1'b0;
    else if (wd_fired)
      wd_sts_q <= 1'b1;
    else if (rst_n && data_wr && idx_q == IDX_STAT1 && wdata[WD_BIT])
      wd_sts_q <= 1'b0;
  end

  always_comb begin
    rdata = 8'h00;
    if (!addr) begin
      rdata = idx_q;
    end else begin
      case (idx_q)
        IDX_STAT0: rdata = {7'b0, por_sts_q};
        IDX_STAT1: rdata = {6'b0, wd_sts_q, 1'b0};
        IDX_CFG:   rdata = {5'b0, cfg_q};
        IDX_BASE0: rdata = BASE_ADDR[7:0];
        IDX_BASE1: rdata = BASE_ADDR[15:8];
        IDX_BASE2: rdata = BASE_ADDR[23:16];
        IDX_BASE3: rdata = BASE_ADDR[31:24];
        default:   rdata = 8'h00;
      endcase
    end
  end

  assign wd_enable = ~cfg_q[0];
  assign wd_res    = cfg_q[2:1];
endmodule

// File: rtl/pm_index_port_chk.sv
module pm_index_port_chk #(
  parameter logic [31:0] BASE_ADDR = 32'hFEB0_0000
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       addr,
  input logic       wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       wd_fired,
  input logic       wd_enable,
  input logic [1:0] wd_res,
  input logic [7:0] idx,
  input logic       wd_sts
);
  a_r1_index_read: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr && !addr) |=> (idx == $past(wdata)));

  a_r3_cfg_visible: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (addr && idx == 8'h69) |-> (rdata[0] == !wd_enable && rdata[2:1] == wd_res && rdata[7:3] == 5'b0));

  a_r4_fire_sets: assert property (@(posedge clk) disable iff (!por_n)
    wd_fired |=> wd_sts);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sts && !(wr && addr && idx == 8'h45 && wdata[1])) |=> wd_sts);

  a_r6_w1c: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr && addr && idx == 8'h45 && wdata[1] && !wd_fired) |=> !wd_sts);

  a_r8_base_lsb: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (addr && idx == 8'h6c) |-> (rdata == BASE_ADDR[7:0]));

  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (addr && idx == 8'h00) |-> (rdata == 8'h00));

  a_r10_held: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (!wd_enable && wd_res == 2'b00 && idx == 8'h00));
endmodule

bind pm_index_port pm_index_port_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr(wr),
  .wdata(wdata), .rdata(rdata), .wd_fired(wd_fired), .wd_enable(wd_enable),
  .wd_res(wd_res), .idx(idx_q), .wd_sts(wd_sts_q)
);

// File: tb/pm_index_port_test.sv
module pm_index_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFEB0_1234;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1;
  logic addr = 1'b0, wr = 1'b0, wd_fired = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wd_enable;
  logic [1:0] wd_res;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_index_port #(.BASE_ADDR(BASE)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr(wr),
    .wdata(wdata), .rdata(rdata), .wd_fired(wd_fired),
    .wd_enable(wd_enable), .wd_res(wd_res)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(1'b0, i);
    bus_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    bus_wr(1'b0, i);
    addr = 1'b1;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    addr = 1'b0;
    #1 check("R1 index after reset", rdata, 8'h00);
    check("R2 enable after reset", {7'b0, wd_enable}, 8'h00);
    check("R2 res after reset", {6'b0, wd_res}, 8'h00);
    reg_rd(8'h69, v); check("R2 cfg after reset", v, 8'h01);
    reg_rd(8'h44, v); check("R7 por status", v, 8'h01);
    reg_rd(8'h45, v); check("R4 wd status clear at power-on", v, 8'h00);
  endtask

  task automatic t_index;
    bus_wr(1'b0, 8'hA5);
    addr = 1'b0;
    #1 check("R1 index readback", rdata, 8'hA5);
  endtask

  task automatic t_cfg;
    logic [7:0] v;
    reg_wr(8'h69, 8'hFE);
    check("R3 enable", {7'b0, wd_enable}, 8'h01);
    check("R3 res 11", {6'b0, wd_res}, 8'h03);
    #1 check("R3 cfg readback", rdata, 8'h06);
    reg_wr(8'h69, 8'h03);
    check("R3 disable", {7'b0, wd_enable}, 8'h00);
    check("R3 res 01", {6'b0, wd_res}, 8'h01);
    reg_rd(8'h69, v); check("R3 cfg readback 2", v, 8'h03);
  endtask

  task automatic t_base;
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      reg_rd(8'h6c + 8'(k), v);
      check("R8 base byte", v, BASE[8*k +: 8]);
    end
    reg_wr(8'h6d, 8'hFF);
    #1 check("R8 base write ignored", rdata, BASE[15:8]);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    reg_wr(8'h50, 8'hFF);
    #1 check("R9 unimplemented reads 0", rdata, 8'h00);
    reg_rd(8'h69, v); check("R9 cfg untouched", v, 8'h03);
    reg_rd(8'h44, v); check("R9 status untouched", v, 8'h01);
  endtask

  task automatic t_fire;
    logic [7:0] v;
    @(negedge clk); wd_fired = 1'b1;
    @(negedge clk); wd_fired = 1'b0;
    reg_rd(8'h45, v); check("R4 fired sets bit 1", v, 8'h02);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    addr = 1'b0;
    #1 check("R10 index held", rdata, 8'h00);
    check("R10 enable held", {7'b0, wd_enable}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    reg_rd(8'h45, v); check("R5 survives rst_n", v, 8'h02);
    reg_rd(8'h69, v); check("R10 cfg restored", v, 8'h01);
    reg_rd(8'h44, v); check("R7 unchanged by rst_n", v, 8'h01);
    reg_wr(8'h45, 8'hFD);
    #1 check("R6 write 0 keeps", rdata, 8'h02);
    reg_wr(8'h45, 8'h02);
    #1 check("R6 write 1 clears", rdata, 8'h00);
    @(negedge clk);
    addr = 1'b1; wr = 1'b1; wdata = 8'h02; wd_fired = 1'b1;
    @(negedge clk);
    wr = 1'b0; wd_fired = 1'b0;
    #1 check("R6 fire wins", rdata, 8'h02);
  endtask

  task automatic t_por;
    logic [7:0] v;
    reg_wr(8'h44, 8'h01);
    #1 check("R7 w1c clears", rdata, 8'h00);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    reg_rd(8'h45, v); check("R5 cleared by por_n", v, 8'h00);
    reg_rd(8'h44, v); check("R7 set by por_n", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_index();
    t_cfg();
    t_base();
    t_unimpl();
    t_fire();
    t_por();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule